// File: doc/BRIEF.md
# Segmented DAC Code Splitter

This block prepares the digital drive for one channel of a hybrid audio converter. Each converter uses a coarse binary-weighted current array, a switched compensating current and a fine one-bit source. The block takes an 18-bit two's-complement sample on a load strobe. For samples above zero it removes the weight of a selectable code bit and raises a flag, so that the analog side adds an equal current back. The block then converts the adjusted value to offset binary.

The top ten bits of that unsigned value go straight to the coarse array. The eight bits below them become the input of a first-order noise shaper. The shaper runs every system clock and emits a one-bit stream whose weight equals the coarse LSB. The system clock runs between 48 and 384 times the sample rate. The shaper residue is never discarded at a sample change, so the quantisation error from one sample carries into the next.

Top module: `segdac_splitter`

## Requirements
- R1: `sample_in` and `offset_pos` are captured only on a clock edge where `load_stb` is 1. `coarse_code` and `offset_en` show the new result after that edge and do not change otherwise, whatever the data inputs do.
- R2: Let the adjusted sample be held in 18-bit two's complement, and let the unsigned code be that value with its top bit inverted. `coarse_code` equals bits 17..8 of the unsigned code, and the fine fraction equals bits 7..0.
- R3: A sample strictly greater than zero, with a valid position, has the weight 2^(18-p) subtracted and `offset_en` set to 1. A zero or negative sample is passed unchanged with `offset_en` at 0.
- R4: `offset_pos` counts code bits from 1 at the MSB. Values 2 to 18 are valid, so 9 gives weight 512, 4 gives 16384 and 18 gives 1. Any other value disables the offset: no subtraction and `offset_en` is 0.
- R5: While the fraction f is held, any 256 consecutive `fine_bit` values contain exactly f ones.
- R6: Over any shorter run of N cycles with f held, the count of ones lies between floor(N*f/256) and ceil(N*f/256).
- R7: The shaper residue survives a new load. Counted from reset, the total number of ones equals floor(S/256), where S is the sum of the fractions applied over all clock edges. A zero fraction yields no ones.
- R8: A synchronous reset gives `coarse_code` = 512 (the code of a zero sample), `offset_en` = 0, `fine_bit` = 0, and an empty residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the shaper rate |
| rst | input | 1 | Synchronous reset, active high |
| load_stb | input | 1 | Capture strobe for a new sample |
| sample_in | input | 18 | Two's-complement sample |
| offset_pos | input | 5 | Offset bit position, 1 = MSB |
| coarse_code | output | 10 | Code for the coarse current array |
| offset_en | output | 1 | Switches in the compensating current |
| fine_bit | output | 1 | Noise-shaped one-bit stream |

## Verification
On every cycle, the assertions check four things:
- Outputs hold between strobes.
- Reset returns the outputs to their cleared values.
- A negative sample or an invalid position never raises the offset flag.
- A zero fraction never emits a one, and a full fraction on a non-empty residue always emits a one.

Only the bench scenarios can show that the coarse code and fraction are correct for each sample and position. They also show the exact count of ones in each 256-cycle window and the bounds on short windows. Finally, they show that the running total of ones from reset agrees with the running sum of fractions, which is the evidence that the residue is kept across loads.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  localparam int DEF_SAMPLE_W = 18;
  localparam int DEF_COARSE_W = 10;
  localparam int DEF_POS_W    = 5;
endpackage

// File: rtl/segdac_split.sv
module segdac_split #(
  parameter int SAMPLE_W = segdac_pkg::DEF_SAMPLE_W,
  parameter int COARSE_W = segdac_pkg::DEF_COARSE_W,
  parameter int POS_W    = segdac_pkg::DEF_POS_W
) (
  input  logic [SAMPLE_W-1:0]          sample,
  input  logic [POS_W-1:0]             pos,
  output logic [COARSE_W-1:0]          coarse,
  output logic [SAMPLE_W-COARSE_W-1:0] frac,
  output logic                         off_en,
  output logic                         pos_ok
);
  localparam int FRAC_W = SAMPLE_W - COARSE_W;
  localparam int MSB    = SAMPLE_W - 1;

  function automatic logic pos_valid(input logic [POS_W-1:0] p);
    return (p >= POS_W'(2)) && (p <= POS_W'(SAMPLE_W));
  endfunction

  function automatic logic [SAMPLE_W-1:0] bit_weight(input logic [POS_W-1:0] p);
    int sh;
    sh = SAMPLE_W - int'(p);
    return SAMPLE_W'(1) << sh;
  endfunction

  function automatic logic above_zero(input logic [SAMPLE_W-1:0] s);
    return !s[MSB] && (|s);
  endfunction

  logic [SAMPLE_W-1:0] weight;
  logic [SAMPLE_W-1:0] adjusted;
  logic [SAMPLE_W-1:0] ucode;

  always_comb begin
    pos_ok   = pos_valid(pos);
    off_en   = pos_ok && above_zero(sample);
    weight   = off_en ? bit_weight(pos) : '0;
    adjusted = sample - weight;
    ucode    = {~adjusted[MSB], adjusted[MSB-1:0]};
    coarse   = ucode[MSB -: COARSE_W];
    frac     = ucode[FRAC_W-1:0];
  end
endmodule

// File: rtl/segdac_hold.sv
module segdac_hold #(
  parameter int COARSE_W = segdac_pkg::DEF_COARSE_W,
  parameter int FRAC_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_stb,
  input  logic [COARSE_W-1:0] coarse_d,
  input  logic [FRAC_W-1:0]   frac_d,
  input  logic                off_d,
  output logic [COARSE_W-1:0] coarse_q,
  output logic [FRAC_W-1:0]   frac_q,
  output logic                off_q
);
  localparam logic [COARSE_W-1:0] MID = {1'b1, {(COARSE_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      coarse_q <= MID;
      frac_q   <= '0;
      off_q    <= 1'b0;
    end else if (load_stb) begin
      coarse_q <= coarse_d;
      frac_q   <= frac_d;
      off_q    <= off_d;
    end
  end

  p_hold_between_loads_r1: assert property (@(posedge clk) disable iff (rst)
    !load_stb |=> ($stable(coarse_q) && $stable(off_q) && $stable(frac_q)));

  p_reset_state_r8: assert property (@(posedge clk)
    rst |=> (coarse_q == MID && frac_q == '0 && !off_q));
endmodule

// File: rtl/segdac_shaper.sv
module segdac_shaper #(
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FRAC_W-1:0] frac,
  output logic              bit_out
);
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;
  logic              carry;

  always_comb begin
    sum   = {1'b0, acc} + {1'b0, frac};
    carry = sum[FRAC_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      bit_out <= 1'b0;
    end else begin
      acc     <= sum[FRAC_W-1:0];
      bit_out <= carry;
    end
  end

  p_zero_frac_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (frac == '0) |=> !bit_out);

  p_full_frac_fires_r5: assert property (@(posedge clk) disable iff (rst)
    ((frac == '1) && (acc != '0)) |=> bit_out);

  p_reset_empty_r8: assert property (@(posedge clk)
    rst |=> (acc == '0 && !bit_out));
endmodule

// File: rtl/segdac_splitter.sv
module segdac_splitter #(
  parameter int SAMPLE_W = segdac_pkg::DEF_SAMPLE_W,
  parameter int COARSE_W = segdac_pkg::DEF_COARSE_W,
  parameter int POS_W    = segdac_pkg::DEF_POS_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_stb,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic [POS_W-1:0]    offset_pos,
  output logic [COARSE_W-1:0] coarse_code,
  output logic                offset_en,
  output logic                fine_bit
);
  localparam int FRAC_W = SAMPLE_W - COARSE_W;

  logic [COARSE_W-1:0] coarse_d;
  logic [FRAC_W-1:0]   frac_d;
  logic [FRAC_W-1:0]   frac_q;
  logic                off_d;
  logic                pos_ok;

  segdac_split #(.SAMPLE_W(SAMPLE_W), .COARSE_W(COARSE_W), .POS_W(POS_W)) u_split (
    .sample (sample_in),
    .pos    (offset_pos),
    .coarse (coarse_d),
    .frac   (frac_d),
    .off_en (off_d),
    .pos_ok (pos_ok)
  );

  segdac_hold #(.COARSE_W(COARSE_W), .FRAC_W(FRAC_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .load_stb (load_stb),
    .coarse_d (coarse_d),
    .frac_d   (frac_d),
    .off_d    (off_d),
    .coarse_q (coarse_code),
    .frac_q   (frac_q),
    .off_q    (offset_en)
  );

  segdac_shaper #(.FRAC_W(FRAC_W)) u_shaper (
    .clk     (clk),
    .rst     (rst),
    .frac    (frac_q),
    .bit_out (fine_bit)
  );

  p_bad_pos_no_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (load_stb && !pos_ok) |=> !offset_en);

  p_negative_no_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (load_stb && sample_in[SAMPLE_W-1]) |=> !offset_en);
endmodule

// File: tb/segdac_splitter_test.sv
module segdac_splitter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        load_stb;
  logic [17:0] sample_in;
  logic [4:0]  offset_pos;
  logic [9:0]  coarse_code;
  logic        offset_en;
  logic        fine_bit;

  int checks = 0;
  int errors = 0;
  longint tot_frac = 0;
  longint tot_ones = 0;
  int m_frac = 0;
  int pend_frac = 0;
  bit counting = 0;
  bit done = 0;

  always #10 clk = ~clk;

  segdac_splitter uut (
    .clk(clk), .rst(rst), .load_stb(load_stb), .sample_in(sample_in),
    .offset_pos(offset_pos), .coarse_code(coarse_code),
    .offset_en(offset_en), .fine_bit(fine_bit)
  );

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_range(input int got, input int lo, input int hi, input string tag);
    checks++;
    if (got < lo || got > hi) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d..%0d", tag, got, lo, hi);
    end
  endtask

  function automatic void model(input logic [17:0] v, input int p,
                                output int coarse, output int frac, output int off);
    int s;
    int u;
    s = (v >= 18'd131072) ? int'(v) - 262144 : int'(v);
    off = (p >= 2 && p <= 18 && s > 0) ? 1 : 0;
    if (off == 1) s = s - (1 << (18 - p));
    u = s + 131072;
    coarse = u / 256;
    frac = u % 256;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (counting) begin
      tot_frac += m_frac;
      tot_ones += fine_bit;
    end
    if (load_stb) m_frac = pend_frac;
  endtask

  task automatic run_sample(input logic [17:0] v, input int p);
    int ec, ef, eo, w256, w48, lo, hi;
    logic [9:0] seen;
    model(v, p, ec, ef, eo);
    sample_in = v;
    offset_pos = 5'(p);
    load_stb = 1'b1;
    pend_frac = ef;
    tick();
    load_stb = 1'b0;
    chk(int'(coarse_code), ec, "R2 coarse code");
    chk(int'(offset_en), eo, (p >= 2 && p <= 18) ? "R3 offset flag" : "R4 offset flag bad pos");
    seen = coarse_code;
    w256 = 0;
    w48 = 0;
    for (int k = 1; k <= 259; k++) begin
      if (k == 100) begin
        sample_in = 18'($urandom);
        offset_pos = 5'($urandom);
      end
      tick();
      if (k <= 256) w256 += int'(fine_bit);
      if (k <= 48) w48 += int'(fine_bit);
    end
    chk(int'(coarse_code), int'(seen), "R1 hold without strobe");
    chk(w256, ef, "R5 ones in 256 cycles");
    lo = (48 * ef) / 256;
    hi = (48 * ef + 255) / 256;
    chk_range(w48, lo, hi, "R6 ones in 48 cycles");
    chk(int'(tot_ones), int'(tot_frac / 256), "R7 cumulative ones");
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    load_stb = 1'b0;
    sample_in = '0;
    offset_pos = 5'd9;
    tick(); tick(); tick();
    chk(int'(coarse_code), 512, "R8 reset coarse");
    chk(int'(offset_en), 0, "R8 reset flag");
    chk(int'(fine_bit), 0, "R8 reset fine bit");
    rst = 1'b0;
    counting = 1;
    for (int k = 0; k < 20; k++) tick();
    chk(int'(tot_ones), 0, "R7 zero fraction quiet");
    run_sample(18'h1FFFF, 9);
    run_sample(18'h20000, 9);
    run_sample(18'h00000, 9);
    run_sample(18'h00001, 9);
    run_sample(18'h3FFFF, 9);
    run_sample(18'h00001, 4);
    run_sample(18'h1FFFF, 4);
    run_sample(18'h00005, 18);
    run_sample(18'h00280, 9);
    run_sample(18'h00280, 1);
    run_sample(18'h00280, 0);
    run_sample(18'h00280, 19);
    run_sample(18'h00080, 9);
    run_sample(18'h00080, 9);
    for (int k = 0; k < 16; k++) begin
      int p;
      p = (k % 3 == 0) ? 9 : (k % 3 == 1) ? 4 : int'($urandom % 32);
      run_sample(18'($urandom), p);
    end
    rst = 1'b1;
    counting = 0;
    tick();
    rst = 1'b0;
    chk(int'(coarse_code), 512, "R8 mid-run reset coarse");
    chk(int'(offset_en), 0, "R8 mid-run reset flag");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule